// File: doc/BRIEF.md
# 2x2 Cluster Transverse-Energy Finder

This block serves one front-end board that reads a patch of calorimeter cells laid out as 8 columns by 4 rows. On every clock it takes one new set of pedestal-corrected 12-bit samples, one for each cell. It scales each sample by a per-cell calibration gain into an 8-bit transverse-energy code. That code clamps at 255, which stands for the full-scale energy or anything above it.

From these codes the block forms the sum of every 2x2 group of adjacent cells. Each group is named by its lower-left cell. Groups in the rightmost column or the top row reach past the board edge. For those groups the missing cells come from 8-bit values that the neighbouring boards deliver:

- a right-side column input,
- a top row input,
- a single top-right corner input.

The block reports the largest group sum, clamped to 8 bits, together with the address of its anchor cell. It also drives its own left column and bottom row codes out, so that the boards to its left and below can use them.

The block is fully pipelined. It accepts a new crossing every clock and has a fixed latency. The codes for a crossing appear on the edge outputs one clock after its samples. The neighbour values for that crossing must be presented during that same clock. The maximum cluster follows one clock later.

Top module: `cluster_et_finder`

## Requirements
- R1: The code of a cell is floor(sample * gain / 16), where the sample is 12 bits and the gain is 8 bits. The code appears one clock after the sample is presented.
- R2: A code whose scaled value exceeds 255 is output as 255.
- R3: `edge_left` bits [8r+7:8r] carry the code of the cell in column 0, row r. `edge_bottom` bits [8c+7:8c] carry the code of the cell in column c, row 0. Cell (c,r) uses channel index r*8+c of the sample and gain buses.
- R4: The group anchored at (c,r) sums cells (c,r), (c+1,r), (c,r+1) and (c+1,r+1). A cell in column 8 is taken from `nbr_right` row r (bits [8r+7:8r]). A cell in row 4 is taken from `nbr_top` column c (bits [8c+7:8c]). Cell (8,4) is taken from `nbr_corner`.
- R5: `max_sum` is the largest group sum, output as 255 when that sum exceeds 255. `max_addr` is the anchor address r*8+c of that group.
- R6: When several groups share the largest sum, the one with the lowest anchor address is reported.
- R7: Samples are accepted on every clock. The neighbour inputs of a crossing are sampled one clock after its samples. `max_sum` and `max_addr` for that crossing appear two clocks after its samples, with no interference between consecutive crossings.
- R8: While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_in | input | 384 | 32 pedestal-corrected samples, 12 bits each, channel r*8+c |
| gain_in | input | 256 | 32 calibration gains, 8 bits each, unity gain is 16 |
| nbr_right | input | 32 | Codes of the 4 cells right of the patch, one per row |
| nbr_top | input | 64 | Codes of the 8 cells above the patch, one per column |
| nbr_corner | input | 8 | Code of the cell above and right of the patch |
| edge_left | output | 32 | Own column-0 codes, one per row |
| edge_bottom | output | 64 | Own row-0 codes, one per column |
| max_sum | output | 8 | Largest 2x2 sum, clamped to 255 |
| max_addr | output | 5 | Anchor address of the largest group |

## Verification
A lone interior cell tests whether the anchor mapping and the lowest-address rule pick the right one of the four groups that share the cell. Separate patterns light only a right-side, top or corner neighbour input, which shows whether the edge groups fetch their cells from the correct neighbour bus. Varied per-cell gains and full-scale samples tell the scaling apart from the two clamps: the per-cell clamp and the group-sum clamp. A back-to-back stream with different neighbour values on each crossing exposes any misalignment between the pipeline stages.

// File: rtl/cluster_et_finder.sv
module cluster_et_finder #(
  parameter int COLS   = 8,
  parameter int ROWS   = 4,
  parameter int AW     = 12,
  parameter int GW     = 8,
  parameter int EW     = 8,
  parameter int GSHIFT = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [COLS*ROWS*AW-1:0]     adc_in,
  input  logic [COLS*ROWS*GW-1:0]     gain_in,
  input  logic [ROWS*EW-1:0]          nbr_right,
  input  logic [COLS*EW-1:0]          nbr_top,
  input  logic [EW-1:0]               nbr_corner,
  output logic [ROWS*EW-1:0]          edge_left,
  output logic [COLS*EW-1:0]          edge_bottom,
  output logic [EW-1:0]               max_sum,
  output logic [$clog2(COLS*ROWS)-1:0] max_addr
);
  localparam int N  = COLS * ROWS;
  localparam int IW = $clog2(N);
  localparam int SW = EW + 2;
  localparam int PW = AW + GW;
  localparam int QW = PW - GSHIFT;
  localparam logic [EW-1:0] FULL = {EW{1'b1}};

  logic [EW-1:0] et_q [N];
  logic [EW-1:0] grid [ROWS+1][COLS+1];
  logic [SW-1:0] gsum [N];
  logic [SW-1:0] best_s;
  logic [IW-1:0] best_i;

  for (genvar ch = 0; ch < N; ch++) begin : g_conv
    logic [PW-1:0] prod;
    logic [QW-1:0] scaled;
    logic [EW-1:0] et_d;
    assign prod   = PW'(adc_in[ch*AW +: AW]) * PW'(gain_in[ch*GW +: GW]);
    assign scaled = prod[PW-1:GSHIFT];
    assign et_d   = (|scaled[QW-1:EW]) ? FULL : scaled[EW-1:0];
    always_ff @(posedge clk)
      if (!rst_n) et_q[ch] <= '0;
      else        et_q[ch] <= et_d;
  end

  for (genvar r = 0; r <= ROWS; r++) begin : g_row
    for (genvar c = 0; c <= COLS; c++) begin : g_col
      if (r < ROWS && c < COLS) begin : g_own
        assign grid[r][c] = et_q[r*COLS+c];
      end else if (r < ROWS) begin : g_right
        assign grid[r][c] = nbr_right[r*EW +: EW];
      end else if (c < COLS) begin : g_top
        assign grid[r][c] = nbr_top[c*EW +: EW];
      end else begin : g_corner
        assign grid[r][c] = nbr_corner;
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_sr
    for (genvar c = 0; c < COLS; c++) begin : g_sc
      assign gsum[r*COLS+c] = SW'(grid[r][c])   + SW'(grid[r][c+1])
                            + SW'(grid[r+1][c]) + SW'(grid[r+1][c+1]);
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_el
    assign edge_left[r*EW +: EW] = et_q[r*COLS];
  end
  for (genvar c = 0; c < COLS; c++) begin : g_eb
    assign edge_bottom[c*EW +: EW] = et_q[c];
  end

  always_comb begin
    best_s = gsum[0];
    best_i = '0;
    for (int i = 1; i < N; i++)
      if (gsum[i] > best_s) begin
        best_s = gsum[i];
        best_i = IW'(i);
      end
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      max_sum  <= '0;
      max_addr <= '0;
    end else begin
      max_sum  <= (|best_s[SW-1:EW]) ? FULL : best_s[EW-1:0];
      max_addr <= best_i;
    end
endmodule

// File: rtl/cluster_et_finder_chk.sv
module cluster_et_finder_chk #(
  parameter int COLS = 8,
  parameter int ROWS = 4,
  parameter int AW   = 12,
  parameter int GW   = 8,
  parameter int EW   = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [COLS*ROWS*AW-1:0]       adc_in,
  input logic [COLS*ROWS*GW-1:0]       gain_in,
  input logic [ROWS*EW-1:0]            nbr_right,
  input logic [COLS*EW-1:0]            nbr_top,
  input logic [EW-1:0]                 nbr_corner,
  input logic [COLS*EW-1:0]            edge_bottom,
  input logic [EW-1:0]                 max_sum,
  input logic [$clog2(COLS*ROWS)-1:0]  max_addr
);
  a_r1_zero_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_in[GW-1:0] == '0) |=> (edge_bottom[EW-1:0] == '0));

  a_r2_cell_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (&adc_in[AW-1:0] && &gain_in[GW-1:0]) |=> (&edge_bottom[EW-1:0]));

  a_r4_corner_full: assert property (@(posedge clk) disable iff (!rst_n)
    (&nbr_corner) |=> (&max_sum));

  a_r5_dominates: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (max_sum >= $past(edge_bottom[EW-1:0])));

  a_r6_all_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_in == '0) ##1 (nbr_right == '0 && nbr_top == '0 && nbr_corner == '0)
    |=> (max_sum == '0 && max_addr == '0));
endmodule

bind cluster_et_finder cluster_et_finder_chk #(
  .COLS(COLS), .ROWS(ROWS), .AW(AW), .GW(GW), .EW(EW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .adc_in(adc_in), .gain_in(gain_in),
  .nbr_right(nbr_right), .nbr_top(nbr_top), .nbr_corner(nbr_corner),
  .edge_bottom(edge_bottom), .max_sum(max_sum), .max_addr(max_addr)
);

// File: tb/test_cluster_et_finder.sv
module test_cluster_et_finder;
  localparam int COLS = 8, ROWS = 4, AW = 12, GW = 8, EW = 8, GSHIFT = 4;
  localparam int N = COLS * ROWS, IW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic [N*AW-1:0]    adc_in = '0;
  logic [N*GW-1:0]    gain_in = '0;
  logic [ROWS*EW-1:0] nbr_right = '0;
  logic [COLS*EW-1:0] nbr_top = '0;
  logic [EW-1:0]      nbr_corner = '0;
  logic [ROWS*EW-1:0] edge_left;
  logic [COLS*EW-1:0] edge_bottom;
  logic [EW-1:0]      max_sum;
  logic [IW-1:0]      max_addr;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cluster_et_finder i_cluster_et_finder (
    .clk(clk), .rst_n(rst_n), .adc_in(adc_in), .gain_in(gain_in),
    .nbr_right(nbr_right), .nbr_top(nbr_top), .nbr_corner(nbr_corner),
    .edge_left(edge_left), .edge_bottom(edge_bottom),
    .max_sum(max_sum), .max_addr(max_addr));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N*EW-1:0] conv(logic [N*AW-1:0] a, logic [N*GW-1:0] g);
    logic [N*EW-1:0] e;
    for (int i = 0; i < N; i++) begin
      longint p = (longint'(a[i*AW +: AW]) * longint'(g[i*GW +: GW])) >> GSHIFT;
      e[i*EW +: EW] = (p > 255) ? 8'hFF : p[7:0];
    end
    return e;
  endfunction

  function automatic int cellv(logic [N*EW-1:0] e, logic [ROWS*EW-1:0] nr,
                               logic [COLS*EW-1:0] nt, logic [EW-1:0] nc, int c, int r);
    if (c < COLS && r < ROWS) return int'(e[(r*COLS+c)*EW +: EW]);
    if (r < ROWS) return int'(nr[r*EW +: EW]);
    if (c < COLS) return int'(nt[c*EW +: EW]);
    return int'(nc);
  endfunction

  task automatic expect_max(logic [N*EW-1:0] e, logic [ROWS*EW-1:0] nr,
                            logic [COLS*EW-1:0] nt, logic [EW-1:0] nc,
                            output int bs, output int bi);
    bs = -1; bi = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int s = cellv(e,nr,nt,nc,c,r) + cellv(e,nr,nt,nc,c+1,r)
              + cellv(e,nr,nt,nc,c,r+1) + cellv(e,nr,nt,nc,c+1,r+1);
        if (s > bs) begin bs = s; bi = r*COLS + c; end
      end
    if (bs > 255) bs = 255;
  endtask

  task automatic check_edges(string tag, logic [N*EW-1:0] e);
    logic [ROWS*EW-1:0] el;
    logic [COLS*EW-1:0] eb;
    for (int r = 0; r < ROWS; r++) el[r*EW +: EW] = e[(r*COLS)*EW +: EW];
    for (int c = 0; c < COLS; c++) eb[c*EW +: EW] = e[c*EW +: EW];
    check({tag, " R1 R3 edge_left"}, 64'(edge_left), 64'(el));
    check({tag, " R1 R3 edge_bottom"}, 64'(edge_bottom), 64'(eb));
  endtask

  task automatic crossing(string tag, logic [N*AW-1:0] a, logic [N*GW-1:0] g,
                          logic [ROWS*EW-1:0] nr, logic [COLS*EW-1:0] nt, logic [EW-1:0] nc);
    logic [N*EW-1:0] e;
    int bs, bi;
    e = conv(a, g);
    @(negedge clk); adc_in = a; gain_in = g;
    @(negedge clk); check_edges(tag, e);
    nbr_right = nr; nbr_top = nt; nbr_corner = nc;
    @(negedge clk);
    expect_max(e, nr, nt, nc, bs, bi);
    check({tag, " R5 max_sum"}, 64'(max_sum), 64'(bs));
    check({tag, " R6 max_addr"}, 64'(max_addr), 64'(bi));
  endtask

  function automatic logic [N*GW-1:0] unity();
    logic [N*GW-1:0] g;
    for (int i = 0; i < N; i++) g[i*GW +: GW] = 8'd16;
    return g;
  endfunction

  function automatic logic [N*AW-1:0] one_cell(int c, int r, int v);
    logic [N*AW-1:0] a = '0;
    a[(r*COLS+c)*AW +: AW] = AW'(v);
    return a;
  endfunction

  task automatic t_reset();
    check("R8 reset edge_left", 64'(edge_left), 0);
    check("R8 reset edge_bottom", 64'(edge_bottom), 0);
    check("R8 reset max_sum", 64'(max_sum), 0);
    check("R8 reset max_addr", 64'(max_addr), 0);
  endtask

  task automatic t_interior();
    crossing("interior R4", one_cell(3, 1, 150), unity(), '0, '0, '0);
    check("interior R6 anchor", 64'(max_addr), 2);
  endtask

  task automatic t_gains();
    logic [N*AW-1:0] a;
    logic [N*GW-1:0] g;
    for (int i = 0; i < N; i++) begin
      a[i*AW +: AW] = AW'(37*i + 5);
      g[i*GW +: GW] = GW'(7*i);
    end
    crossing("gains R1", a, g, '0, '0, '0);
  endtask

  task automatic t_saturate();
    logic [N*AW-1:0] a = '0;
    logic [N*GW-1:0] g = unity();
    a[0*AW +: AW] = 12'hFFF; g[0*GW +: GW] = 8'hFF;
    a[(1*COLS+5)*AW +: AW] = 200; a[(1*COLS+6)*AW +: AW] = 200;
    a[(2*COLS+5)*AW +: AW] = 200; a[(2*COLS+6)*AW +: AW] = 200;
    crossing("saturate R2", a, g, '0, '0, '0);
    check("saturate R5 clamp", 64'(max_sum), 255);
  endtask

  task automatic t_right();
    crossing("right R4", one_cell(7, 2, 20), unity(), {8'd0, 8'd90, 8'd0, 8'd0}, '0, '0);
    check("right R4 addr", 64'(max_addr), 15);
  endtask

  task automatic t_top();
    logic [COLS*EW-1:0] nt = '0;
    nt[4*EW +: EW] = 120;
    crossing("top R4", '0, unity(), '0, nt, '0);
    check("top R4 addr", 64'(max_addr), 27);
  endtask

  task automatic t_corner();
    logic [COLS*EW-1:0] nt = '0;
    nt[7*EW +: EW] = 10;
    crossing("corner R4", '0, unity(), '0, nt, 8'd77);
    check("corner R4 sum", 64'(max_sum), 87);
    check("corner R4 addr", 64'(max_addr), 31);
  endtask

  task automatic t_tie();
    logic [N*AW-1:0] a = one_cell(1, 0, 60);
    a[(2*COLS+5)*AW +: AW] = 60;
    crossing("tie R6", a, unity(), '0, '0, '0);
    check("tie R6 addr", 64'(max_addr), 0);
  endtask

  task automatic t_stream();
    logic [N*AW-1:0] a [3];
    logic [ROWS*EW-1:0] nr [3];
    logic [N*EW-1:0] e [3];
    a[0] = one_cell(2, 2, 100); nr[0] = {8'd0, 8'd0, 8'd0, 8'd200};
    a[1] = one_cell(6, 3, 30);  nr[1] = '0;
    a[2] = one_cell(0, 3, 180); nr[2] = {8'd40, 8'd0, 8'd0, 8'd0};
    for (int k = 0; k < 3; k++) e[k] = conv(a[k], unity());
    gain_in = unity();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        int bs, bi;
        expect_max(e[k-2], nr[k-2], '0, '0, bs, bi);
        check("stream R7 max_sum", 64'(max_sum), 64'(bs));
        check("stream R7 max_addr", 64'(max_addr), 64'(bi));
      end
      if (k >= 1 && k <= 3) begin
        check_edges("stream R7", e[k-1]);
        nbr_right = nr[k-1]; nbr_top = '0; nbr_corner = '0;
      end
      if (k < 3) adc_in = a[k];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    adc_in = {N{12'd500}}; gain_in = unity(); nbr_corner = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    adc_in = '0; nbr_corner = '0;
    rst_n = 1;
    t_interior();
    t_gains();
    t_saturate();
    t_right();
    t_top();
    t_corner();
    t_tie();
    t_stream();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule